// File: doc/BRIEF.md
# Serial EEPROM Slave Front End

This block is the bus-facing logic of a 256-byte non-volatile store that answers on a two-wire serial bus (I2C). It oversamples the clock and data lines with a faster system clock, finds start and stop conditions, and shifts bytes in most significant bit first. It pulls the data line low to acknowledge and compares the device select byte against a fixed type code and three strap inputs. Write transfers carry a word address and then up to one page of data into a small write buffer. Read transfers stream bytes out from an internal address pointer.

A stop condition that closes a valid write hands the buffered bytes, their start address and their count to a commit sequencer. The sequencer writes one byte into the array for each programming interval. While it runs, the front end stays deaf to the bus, so a master learns that the commit is finished by polling the device select until it is acknowledged. The array is a register file that stands in for the real cells.

Top module: `snv_top`

## Requirements
- R1: After reset the data line is released (sda_low_o = 0), the address pointer is 0 and every array byte reads as 0.
- R2: A select byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal strap_i[2:1:0] in that order; bit 0 = 1 selects a read, 0 a write. Any other select gets no acknowledge.
- R3: In a write, the byte after the select is the word address and is acknowledged, and each of up to 8 following data bytes is acknowledged.
- R4: Data byte k (k = 0..7) of a write lands at address {A[7:3], (A[2:0]+k) mod 8}, where A is the word address, so the transfer wraps inside its aligned 8-byte page.
- R5: A ninth data byte in one write gets no acknowledge, and nothing from that transfer is stored.
- R6: After a stop that closes a write of n = 1..8 data bytes, the device acknowledges nothing for n * PROG_CYCLES clock cycles. It acknowledges its select again once the commit is done.
- R7: Reads return the byte at the pointer and then advance the pointer by one over the full 8-bit range, wrapping from 255 to 0, with no limit on length; a random read sets the pointer with a write of the word address followed by a repeated start with a read select.
- R8: A read that starts without a word address begins at the pointer left by the previous transfer: one past the last byte read, or the page-wrapped address after the last byte written.
- R9: When the master does not acknowledge a read byte, the device releases the data line and sends no further data until the next start.
- R10: A start condition that arrives before a stop discards all buffered write data, including a partially received byte; none of it is stored.
- R11: A stop after a write that carried no complete data byte starts no commit; the device acknowledges its select at once.
- R12: sda_low_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Board straps that set the low three select bits |
| sda_low_o | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |

## Verification
The bench builds the block with its default 256 x 8 array and 8-byte page. It shortens PROG_CYCLES to 400, so a full page commit takes a few thousand cycles and every start offset within a page can be written and committed in one run. The straps are tied to 101, which lets a sweep of all eight select codes and a wrong type code show that exactly one is answered. The pages written sit at the top of the address range, so sequential reads cross from 255 to 0.

// File: rtl/snv_pkg.sv
package snv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } snv_st_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_WADDR,
    RX_WDATA
  } snv_rx_e;
endpackage

// File: rtl/snv_sync.sv
module snv_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;  // idle bus is high
      else         chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/snv_commit.sv
module snv_commit #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lat_we_i,
  input  logic [PAGE_W-1:0] lat_idx_i,
  input  logic [DATA_W-1:0] lat_data_i,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] go_base_i,
  input  logic [PAGE_W:0]   go_cnt_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TMR_W = $clog2(PROG_CYCLES);

  logic [DATA_W-1:0] mem   [DEPTH];
  logic [DATA_W-1:0] latch [PAGE];
  logic [PAGE_W-1:0] idx;
  logic [PAGE_W:0]   cnt;
  logic [ADDR_W-1:0] base;
  logic [TMR_W-1:0]  tmr;
  logic [PAGE_W-1:0] lo;
  logic [ADDR_W-1:0] waddr;
  logic              last, tick;

  assign lo    = base[PAGE_W-1:0] + idx;
  assign waddr = {base[ADDR_W-1:PAGE_W], lo};
  assign last  = ({1'b0, idx} == cnt - 1'b1);
  assign tick  = (tmr == TMR_W'(PROG_CYCLES - 1));
  assign rd_data_o = mem[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE; i++) latch[i] <= '0;
    end else if (lat_we_i) begin
      latch[lat_idx_i] <= lat_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      busy_o <= 1'b0;
      idx    <= '0;
      cnt    <= '0;
      base   <= '0;
      tmr    <= '0;
    end else if (!busy_o) begin
      if (go_i) begin
        busy_o <= 1'b1;
        idx    <= '0;
        cnt    <= go_cnt_i;
        base   <= go_base_i;
        tmr    <= '0;
      end
    end else if (tick) begin
      tmr        <= '0;
      mem[waddr] <= latch[idx];
      idx        <= idx + 1'b1;
      if (last) busy_o <= 1'b0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/snv_proto.sv
module snv_proto
  import snv_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          PAGE_W   = 3,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_low_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              lat_we_o,
  output logic [PAGE_W-1:0] lat_idx_o,
  output logic [7:0]        lat_data_o,
  output logic              go_o,
  output logic [ADDR_W-1:0] go_base_o,
  output logic [PAGE_W:0]   go_cnt_o
);
  localparam int PAGE = 1 << PAGE_W;

  logic scl_q, sda_q, scl_rise, scl_fall, start, stop;
  snv_st_e st;
  snv_rx_e kind;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg, txreg;
  logic [ADDR_W-1:0] ptr, wbase;
  logic [PAGE_W:0]   wcnt;
  logic              nxt_tx, mack;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start     = scl_i & scl_q & sda_q & ~sda_i;
  assign stop      = scl_i & scl_q & ~sda_q & sda_i;
  assign rd_addr_o = ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      st <= ST_IDLE; kind <= RX_DEV;
      bit_cnt <= '0; shreg <= '0; txreg <= '0;
      ptr <= '0; wbase <= '0; wcnt <= '0;
      nxt_tx <= 1'b0; mack <= 1'b0; sda_low_o <= 1'b0;
      lat_we_o <= 1'b0; lat_idx_o <= '0; lat_data_o <= '0;
      go_o <= 1'b0; go_base_o <= '0; go_cnt_o <= '0;
    end else begin
      scl_q    <= scl_i;
      sda_q    <= sda_i;
      lat_we_o <= 1'b0;
      go_o     <= 1'b0;
      if (busy_i) begin
        st <= ST_IDLE; sda_low_o <= 1'b0; wcnt <= '0;
      end else if (start) begin
        st <= ST_RX; kind <= RX_DEV; bit_cnt <= '0;
        sda_low_o <= 1'b0; wcnt <= '0;  // drop any unfinished write
      end else if (stop) begin
        if (wcnt != '0) begin
          go_o <= 1'b1; go_base_o <= wbase; go_cnt_o <= wcnt;
        end
        st <= ST_IDLE; sda_low_o <= 1'b0; wcnt <= '0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              unique case (kind)
                RX_DEV: begin
                  if (shreg[7:1] == {DEV_TYPE, strap_i}) begin
                    sda_low_o <= 1'b1; st <= ST_ACK;
                    nxt_tx <= shreg[0]; kind <= RX_WADDR;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                RX_WADDR: begin
                  ptr <= shreg[ADDR_W-1:0]; wbase <= shreg[ADDR_W-1:0];
                  sda_low_o <= 1'b1; st <= ST_ACK; nxt_tx <= 1'b0;
                  kind <= RX_WDATA;
                end
                default: begin
                  if (wcnt == (PAGE_W+1)'(PAGE)) begin
                    st <= ST_IDLE; wcnt <= '0;  // overflow: no ack, discard
                  end else begin
                    lat_we_o <= 1'b1; lat_idx_o <= wcnt[PAGE_W-1:0];
                    lat_data_o <= shreg; wcnt <= wcnt + 1'b1;
                    ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                    sda_low_o <= 1'b1; st <= ST_ACK; nxt_tx <= 1'b0;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (nxt_tx) begin
                txreg <= rd_data_i; ptr <= ptr + 1'b1;
                sda_low_o <= ~rd_data_i[7]; st <= ST_TX;
              end else begin
                sda_low_o <= 1'b0; st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_low_o <= 1'b0; st <= ST_MACK;
              end else begin
                bit_cnt   <= bit_cnt + 1'b1;
                txreg     <= {txreg[6:0], 1'b0};
                sda_low_o <= ~txreg[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_i;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (mack) begin
                txreg <= rd_data_i; ptr <= ptr + 1'b1;
                sda_low_o <= ~rd_data_i[7]; st <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/snv_top.sv
module snv_top #(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 3,
  parameter int         PROG_CYCLES = 1000,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_low_o
);
  logic              scl_s, sda_s, busy, lat_we, go;
  logic [PAGE_W-1:0] lat_idx;
  logic [7:0]        lat_data, rd_data;
  logic [ADDR_W-1:0] rd_addr, go_base;
  logic [PAGE_W:0]   go_cnt;

  snv_sync #(.W(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  snv_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_TYPE(DEV_TYPE)) u_proto (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .strap_i   (strap_i),
    .busy_i    (busy),
    .rd_data_i (rd_data),
    .sda_low_o (sda_low_o),
    .rd_addr_o (rd_addr),
    .lat_we_o  (lat_we),
    .lat_idx_o (lat_idx),
    .lat_data_o(lat_data),
    .go_o      (go),
    .go_base_o (go_base),
    .go_cnt_o  (go_cnt)
  );

  snv_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(8),
               .PROG_CYCLES(PROG_CYCLES)) u_commit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lat_we_i  (lat_we),
    .lat_idx_i (lat_idx),
    .lat_data_i(lat_data),
    .go_i      (go),
    .go_base_i (go_base),
    .go_cnt_i  (go_cnt),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .busy_o    (busy)
  );
endmodule

// File: rtl/snv_chk.sv
module snv_chk #(
  parameter int PAGE_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            scl_s,
  input logic            sda_low_o,
  input logic            busy,
  input logic            go,
  input logic [PAGE_W:0] go_cnt
);
  localparam int PAGE = 1 << PAGE_W;

  a_r6_quiet_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_low_o);

  a_r12_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_o) |-> !$past(scl_s));

  a_r5_go_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |-> (go_cnt != '0 && go_cnt <= (PAGE_W+1)'(PAGE)));

  a_r6_go_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |-> !busy);
endmodule

bind snv_top snv_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .sda_low_o(sda_low_o),
  .busy     (busy),
  .go       (go),
  .go_cnt   (go_cnt)
);

// File: tb/sim_snv_top.sv
module sim_snv_top;
  localparam int CLK_P = 10;
  localparam int Q     = 5;
  localparam int PROG  = 400;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV   = {4'b1010, STRAP};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_low;
  wire  sda_bus = sda_m & ~sda_low;

  int n_chk = 0, n_err = 0, viol = 0;
  logic [7:0] shadow [256];
  logic [7:0] ptr_m;
  logic scl_pe = 1'b1, low_prev = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  snv_top #(.PROG_CYCLES(PROG)) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .strap_i  (STRAP),
    .sda_low_o(sda_low)
  );

  // R12 monitor: output must not move while the raw clock line is high
  always @(posedge clk) scl_pe <= scl;
  always @(negedge clk) begin
    if (rst_n && sda_low !== low_prev && scl_pe) viol++;
    low_prev <= sda_low;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    end
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); ack = !sda_bus; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q); d[i] = sda_bus; wt(Q); scl = 1'b0;
    end
    wt(Q); sda_m = give_ack ? 1'b0 : 1'b1; wt(Q);
    scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q); sda_m = 1'b1;
  endtask

  task automatic probe(output bit ack);
    bus_start(); send({DEV, 1'b0}, ack); bus_stop();
  endtask

  task automatic wait_ready();
    bit ack = 1'b0;
    for (int k = 0; k < 60; k++) begin
      probe(ack);
      if (ack) break;
    end
    check(ack, "R6 select answered after commit", int'(ack), 1);
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'(s * 37 + i * 11 + 1);
  endfunction

  task automatic write_tx(input logic [7:0] a, input int n, input int seed);
    bit ack;
    bus_start();
    send({DEV, 1'b0}, ack); check(ack, "R3 select ack", int'(ack), 1);
    send(a, ack);           check(ack, "R3 word address ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      send(pat(seed, i), ack);
      if (i < 8) check(ack, "R3 data ack", int'(ack), 1);
      else begin
        check(!ack, "R5 ninth byte not acked", int'(ack), 0);
        break;
      end
    end
    bus_stop();
    if (n >= 1 && n <= 8) begin
      for (int i = 0; i < n; i++)
        shadow[{a[7:3], 3'(a[2:0] + 3'(i))}] = pat(seed, i);
      ptr_m = {a[7:3], 3'(a[2:0] + 3'(n))};
      probe(ack); check(!ack, "R6 deaf during commit", int'(ack), 0);
      wait_ready();
    end else begin
      ptr_m = a;
      probe(ack); check(ack, "R5/R11 no commit started", int'(ack), 1);
    end
  endtask

  task automatic read_random(input logic [7:0] a, input int n);
    bit ack; logic [7:0] d;
    bus_start();
    send({DEV, 1'b0}, ack); send(a, ack);
    bus_start();
    send({DEV, 1'b1}, ack); check(ack, "R7 read select ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] ai;
      ai = a + 8'(i);
      recv(i != n - 1, d);
      check(d === shadow[ai], "R7/R4 read data", int'(d), int'(shadow[ai]));
    end
    check(sda_low == 1'b0 && sda_bus == 1'b1, "R9 line released after NACK",
          int'(sda_low), 0);
    wt(4*Q);
    check(sda_low == 1'b0, "R9 no further data", int'(sda_low), 0);
    bus_stop();
    ptr_m = a + 8'(n);
  endtask

  task automatic read_current(input int n, input string req);
    bit ack; logic [7:0] d;
    bus_start();
    send({DEV, 1'b1}, ack); check(ack, req, int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, d);
      check(d === shadow[ptr_m], req, int'(d), int'(shadow[ptr_m]));
      ptr_m = ptr_m + 1'b1;
    end
    bus_stop();
  endtask

  task automatic run_all();
    bit ack;
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    ptr_m = 8'h00;
    wt(5);
    check(sda_low == 1'b0, "R1 released in reset", int'(sda_low), 0);
    rst_n = 1'b1; wt(5);
    check(sda_low == 1'b0, "R1 released after reset", int'(sda_low), 0);
    read_current(2, "R1/R8 pointer 0 and zero array");

    // R2: sweep every strap code plus a wrong type code
    for (int s = 0; s < 8; s++) begin
      bus_start(); send({4'b1010, 3'(s), 1'b0}, ack); bus_stop();
      check(ack == (3'(s) == STRAP), "R2 select match", int'(ack), int'(3'(s) == STRAP));
    end
    bus_start(); send({4'b1011, STRAP, 1'b0}, ack); bus_stop();
    check(!ack, "R2 wrong type code", int'(ack), 0);

    // R11: word address only, then immediate select
    write_tx(8'h40, 0, 0);
    read_current(1, "R11/R8 pointer set by word address");

    // R4/R6/R8: every start offset in a page, varied lengths
    for (int off = 0; off < 8; off++) begin
      logic [7:0] a;
      a = {5'(off + 24), 3'(off)};
      write_tx(a, 1 + ((off * 3) % 8), off + 3);
      read_current(1, "R8 pointer after page write");
      read_random({a[7:3], 3'b000}, 8);
    end

    // R5: ninth data byte discards the write
    write_tx(8'h08, 9, 50);
    read_random(8'h08, 8);

    // R10: restart after full and partial bytes drops the write
    bus_start();
    send({DEV, 1'b0}, ack); send(8'h20, ack);
    send(8'hAA, ack); send(8'h55, ack);
    send_bits(8'hFF, 4);
    bus_start();
    send({DEV, 1'b0}, ack);
    bus_stop();
    check(ack, "R10 restart not followed by commit", int'(ack), 1);
    probe(ack);
    check(ack, "R10 still responsive", int'(ack), 1);
    read_random(8'h20, 2);

    // R7: sequential read across 255 -> 0
    write_tx(8'hFE, 2, 60);
    read_random(8'hFD, 5);
    read_current(3, "R7/R8 sequential continues from pointer");

    check(viol == 0, "R12 output moved while SCL high", viol, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        wt(190000);
        n_err++;
        $display("FAIL watchdog: run did not finish (all requirements)");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule